// File: doc/BRIEF.md
# Configuration Register Space with Base Address Decode

This block holds the 256-byte configuration space of a single bus function. A host side issues byte, word or dword reads and writes at any byte offset. Ordinary writes land byte by byte, and each byte is checked against a write-protection map. That map is picked by the header type, which is fixed by a parameter and read back at offset 0x0E.

Six base address registers (at 0x10, 0x14, ... 0x24) and one expansion ROM register (at 0x30) each have a parameterised power-of-two size. An aligned dword write to an implemented one is masked to its size and gets its type bit forced. The block continuously decodes every region from the stored register and the command byte at offset 0x04. The result is a valid flag and a base address per region, which drive the address match of the logic behind it.

Top module: `cfg_space_top`

## Requirements
- R1: After reset every byte reads 0, with these exceptions: offset 0x0E holds HDR_TYPE, and byte 0 of each implemented base register holds its type bit (1 for an I/O region, 0 for memory). The ROM register reads 0, every rgn_valid bit is 0 and every rgn_base field is 0xFFFFFFFF.
- R2: The base register path is taken by an aligned dword write (acc_len 2 or 3) to 0x10+4n of a register with nonzero size S. That write stores (data AND NOT(S-1)) OR type, where type is bit 0, set for I/O. It bypasses byte protection.
- R3: An aligned dword write to 0x30 with nonzero ROM size S stores (data AND NOT(S-1)), with bit 0 copied from the written data as the ROM enable.
- R4: With HDR_TYPE 0x00 or 0x80, ordinary writes leave these bytes unchanged: 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x30-0x33 and 0x3D. All other bytes are writable.
- R5: With any other HDR_TYPE (such as 0x01), ordinary writes leave these bytes unchanged: 0x00-0x03, 0x08-0x0B, 0x0E, 0x38-0x3B and 0x3D. All other bytes are writable.
- R6: An ordinary write covers 1, 2 or 4 bytes for acc_len 0, 1 and 2/3, starting at any offset, with byte k taken from wr_data[8k+7:8k]. Each byte is checked on its own, and nothing past offset 0xFF is written (no wrap to 0x00).
- R7: A read returns its data on rd_data one cycle after rd_en, in little-endian order with unused upper bytes zero. A dword read is honoured only at offsets up to 0xFC and a word read only up to 0xFE. Past those limits the read falls back to a word, or to a single byte.
- R8: I/O region n is valid when command bit 0 is set, its base (register AND NOT(S-1)) is nonzero, base+S-1 does not wrap and exceeds base, and base+S-1 is below 0x10000. rgn_base[32n+31:32n] then holds the base; otherwise the flag is 0 and the field reads 0xFFFFFFFF.
- R9: A memory region is valid when command bit 1 is set, its base is nonzero, and base+S-1 neither wraps nor equals 0xFFFFFFFF. For the ROM (region 6), bit 0 of its register must also be set.
- R10: A base register of size 0 is never valid and acts as ordinary bytes under R4/R5.
- R11: A write to base register bytes that is not an aligned dword (byte, word, or unaligned dword) goes through the ordinary byte path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| acc_len | input | 2 | Access width: 0 byte, 1 word, 2 or 3 dword |
| acc_addr | input | 8 | Byte offset of the access |
| wr_data | input | 32 | Write data, byte k in bits 8k+7:8k |
| rd_data | output | 32 | Registered read data |
| rgn_valid | output | 7 | Per-region decode valid, bit 6 is the ROM |
| rgn_base | output | 224 | Per-region base, 32 bits per region |

## Verification
A write takes effect at the clock edge that samples it. Both region outputs are combinational from the stored bytes, so they settle within the same cycle, and the bench samples them on the falling edge right after that write edge. Read data passes through one register and belongs to the falling edge after the edge that sampled rd_en; the bench samples there and never overlaps a read with a write. Two instances share the stimulus, one per header type, so one write pattern exposes both protection maps.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_BYTES = 256;
  localparam int AW        = $clog2(CFG_BYTES);
  localparam int NUM_BAR   = 6;
  localparam int NUM_RGN   = NUM_BAR + 1;
  localparam int ROM_IDX   = NUM_BAR;

  localparam logic [AW-1:0] BAR_FIRST = 8'h10;
  localparam logic [AW-1:0] ROM_OFF   = 8'h30;
  localparam logic [AW-1:0] HDR_OFF   = 8'h0E;
  localparam logic [AW-1:0] CMD_OFF   = 8'h04;

  // Access width codes on acc_len
  localparam logic [1:0] LEN_BYTE = 2'd0;
  localparam logic [1:0] LEN_WORD = 2'd1;

  function automatic logic [AW-1:0] rgn_offset(int r);
    return (r == ROM_IDX) ? ROM_OFF : BAR_FIRST + AW'(4 * r);
  endfunction

  function automatic int acc_bytes(logic [1:0] len);
    case (len)
      LEN_BYTE: return 1;
      LEN_WORD: return 2;
      default:  return 4;
    endcase
  endfunction

  // Per-byte protection map selected by the header type byte
  function automatic logic byte_writable(logic [7:0] hdr, logic [AW-1:0] a);
    logic ro;
    ro = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || (a == 8'h0E) || (a == 8'h3D);
    if (hdr == 8'h00 || hdr == 8'h80)
      ro = ro || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    else
      ro = ro || (a >= 8'h38 && a <= 8'h3B);
    return !ro;
  endfunction
endpackage

// File: rtl/cfg_wr_ctrl.sv
module cfg_wr_ctrl import cfg_pkg::*; #(
  parameter logic [NUM_RGN-1:0][31:0] REG_SIZE  = {32'h800, 32'd0, 32'd0, 32'd0, 32'h10, 32'h1000, 32'h20},
  parameter logic [NUM_BAR-1:0]       BAR_IS_IO = 6'b000001
) (
  input  logic                  wr_en,
  input  logic [1:0]            len,
  input  logic [AW-1:0]         addr,
  input  logic [31:0]           wdata,
  input  logic [7:0]            hdr,
  output logic                  bar_hit,
  output logic [3:0]            lane_en,
  output logic [3:0][AW-1:0]    lane_addr,
  output logic [3:0][7:0]       lane_data
);
  localparam logic [NUM_RGN-1:0] IO_MASK = {1'b0, BAR_IS_IO};

  logic [31:0]       bar_val;
  logic [3:0][AW:0]  lane_sum;
  int                nbytes;

  // Aligned dword to an implemented region: size mask and forced type bits
  always_comb begin
    bar_hit = 1'b0;
    bar_val = wdata;
    for (int r = 0; r < NUM_RGN; r++) begin
      if (REG_SIZE[r] != 32'd0 && len[1] && addr == rgn_offset(r)) begin
        bar_hit = 1'b1;
        if (r == ROM_IDX)
          bar_val = wdata & (~(REG_SIZE[r] - 32'd1) | 32'd1);
        else
          bar_val = (wdata & ~(REG_SIZE[r] - 32'd1)) | {31'd0, IO_MASK[r]};
      end
    end
  end

  always_comb begin
    nbytes = acc_bytes(len);
    for (int k = 0; k < 4; k++) begin
      lane_sum[k]  = {1'b0, addr} + (AW+1)'(k);
      lane_addr[k] = lane_sum[k][AW-1:0];
      if (bar_hit) begin
        lane_en[k]   = wr_en;
        lane_data[k] = bar_val[8*k +: 8];
      end else begin
        lane_en[k]   = wr_en && (k < nbytes) && !lane_sum[k][AW] &&
                       byte_writable(hdr, lane_sum[k][AW-1:0]);
        lane_data[k] = wdata[8*k +: 8];
      end
    end
  end
endmodule

// File: rtl/cfg_rd_align.sv
module cfg_rd_align import cfg_pkg::*; (
  input  logic [1:0]       len,
  input  logic [AW-1:0]    addr,
  input  logic [3:0][7:0]  bytes_in,
  output logic [31:0]      data
);
  int nbytes;

  always_comb begin
    if (len[1] && addr <= AW'(CFG_BYTES - 4))
      nbytes = 4;
    else if (len != LEN_BYTE && addr <= AW'(CFG_BYTES - 2))
      nbytes = 2;
    else
      nbytes = 1;
    for (int k = 0; k < 4; k++)
      data[8*k +: 8] = (k < nbytes) ? bytes_in[k] : 8'h00;
  end
endmodule

// File: rtl/cfg_region_dec.sv
module cfg_region_dec #(
  parameter logic [31:0] SIZE   = 32'h20,
  parameter bit          IS_IO  = 1'b0,
  parameter bit          IS_ROM = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] bar,
  input  logic        io_en,
  input  logic        mem_en,
  output logic        valid,
  output logic [31:0] base_o
);
  logic [31:0] base;
  logic [32:0] last;
  logic        span_ok;
  logic        space_en;

  always_comb begin
    base     = bar & ~(SIZE - 32'd1);
    last     = {1'b0, base} + {1'b0, SIZE} - 33'd1;
    span_ok  = !last[32] && (last[31:0] > base) && (base != 32'd0);
    space_en = IS_IO ? io_en : (mem_en && (!IS_ROM || bar[0]));
    if (IS_IO)
      valid = (SIZE != 32'd0) && space_en && span_ok && (last[31:16] == 16'd0);
    else
      valid = (SIZE != 32'd0) && space_en && span_ok && (last[31:0] != 32'hFFFF_FFFF);
    base_o = valid ? base : 32'hFFFF_FFFF;
  end

  // R9 / R8: a decoded window is nonzero and aligned to its size
  assert_base_align_R9: assert property (@(posedge clk) disable iff (rst)
    valid |-> (base_o != 32'd0) && ((base_o & (SIZE - 32'd1)) == 32'd0));
endmodule

// File: rtl/cfg_space_top.sv
module cfg_space_top import cfg_pkg::*; #(
  parameter logic [7:0]               HDR_TYPE  = 8'h00,
  parameter logic [NUM_RGN-1:0][31:0] REG_SIZE  = {32'h800, 32'd0, 32'd0, 32'd0, 32'h10, 32'h1000, 32'h20},
  parameter logic [NUM_BAR-1:0]       BAR_IS_IO = 6'b000001
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [1:0]              acc_len,
  input  logic [AW-1:0]           acc_addr,
  input  logic [31:0]             wr_data,
  output logic [31:0]             rd_data,
  output logic [NUM_RGN-1:0]      rgn_valid,
  output logic [NUM_RGN*32-1:0]   rgn_base
);
  localparam logic [NUM_RGN-1:0] IO_MASK = {1'b0, BAR_IS_IO};

  logic [7:0]             mem [CFG_BYTES];
  logic                   bar_hit;
  logic [3:0]             lane_en;
  logic [3:0][AW-1:0]     lane_addr;
  logic [3:0][7:0]        lane_data;
  logic [3:0][7:0]        rd_bytes;
  logic [31:0]            rd_word;

  function automatic logic [7:0] reset_byte(logic [AW-1:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a == HDR_OFF) v = HDR_TYPE;
    for (int r = 0; r < NUM_BAR; r++)
      if (REG_SIZE[r] != 32'd0 && a == rgn_offset(r)) v = {7'd0, IO_MASK[r]};
    return v;
  endfunction

  cfg_wr_ctrl #(.REG_SIZE(REG_SIZE), .BAR_IS_IO(BAR_IS_IO)) u_wr (
    .wr_en(wr_en), .len(acc_len), .addr(acc_addr), .wdata(wr_data),
    .hdr(HDR_TYPE), .bar_hit(bar_hit), .lane_en(lane_en),
    .lane_addr(lane_addr), .lane_data(lane_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CFG_BYTES; i++) mem[i] <= reset_byte(AW'(i));
    end else begin
      for (int k = 0; k < 4; k++)
        if (lane_en[k]) mem[lane_addr[k]] <= lane_data[k];
    end
  end

  always_comb
    for (int k = 0; k < 4; k++) rd_bytes[k] = mem[acc_addr + AW'(k)];

  cfg_rd_align u_rd (.len(acc_len), .addr(acc_addr), .bytes_in(rd_bytes), .data(rd_word));

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 32'd0;
    else if (rd_en) rd_data <= rd_word;
  end

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    localparam logic [AW-1:0] OFF  = rgn_offset(r);
    localparam logic [31:0]   SIZE = REG_SIZE[r];
    logic [31:0] bar_w;
    assign bar_w = {mem[OFF + AW'(3)], mem[OFF + AW'(2)], mem[OFF + AW'(1)], mem[OFF]};

    cfg_region_dec #(.SIZE(SIZE), .IS_IO(IO_MASK[r]), .IS_ROM(r == ROM_IDX)) u_dec (
      .clk(clk), .rst(rst), .bar(bar_w),
      .io_en(mem[CMD_OFF][0]), .mem_en(mem[CMD_OFF][1]),
      .valid(rgn_valid[r]), .base_o(rgn_base[32*r +: 32])
    );

    if (SIZE != 32'd0 && r != ROM_IDX) begin : g_bar_chk
      assert_bar_type_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_len[1] && acc_addr == OFF) |=>
        ((bar_w & (SIZE - 32'd1)) == {31'd0, IO_MASK[r]}));
    end
    if (SIZE != 32'd0 && r == ROM_IDX) begin : g_rom_chk
      assert_rom_enable_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_len[1] && acc_addr == OFF) |=>
        (bar_w[0] == $past(wr_data[0])) && ((bar_w & (SIZE - 32'd2)) == 32'd0));
    end
    if (IO_MASK[r]) begin : g_io_chk
      assert_io_needs_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        rgn_valid[r] |-> mem[CMD_OFF][0]);
    end else begin : g_mem_chk
      assert_mem_needs_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        rgn_valid[r] |-> mem[CMD_OFF][1]);
    end
  end

  assert_hdr_fixed_R1: assert property (@(posedge clk) disable iff (rst)
    mem[HDR_OFF] == HDR_TYPE);

  // R4 and R5: a protected byte keeps its value through a byte write
  assert_ro_byte_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && acc_len == LEN_BYTE && !byte_writable(HDR_TYPE, acc_addr)) |=>
    (mem[$past(acc_addr)] == $past(mem[acc_addr])));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bar_hit && acc_addr == AW'(CFG_BYTES - 1)) |=> (mem[0] == $past(mem[0])));

  assert_rd_width_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && acc_len == LEN_BYTE) |=> (rd_data[31:8] == 24'd0));
endmodule

// File: tb/test_cfg_space_top.sv
module test_cfg_space_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   acc_len = 2'd0;
  logic [7:0]   acc_addr = 8'd0;
  logic [31:0]  wr_data = 32'd0;
  logic [31:0]  rd_a, rd_b;
  logic [6:0]   val_a, val_b;
  logic [223:0] base_a, base_b;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cfg_space_top #(.HDR_TYPE(8'h00)) i_cfg_space_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .acc_len(acc_len),
    .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_a),
    .rgn_valid(val_a), .rgn_base(base_a));

  cfg_space_top #(.HDR_TYPE(8'h01)) i_cfg_space_top_b (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .acc_len(acc_len),
    .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_b),
    .rgn_valid(val_b), .rgn_base(base_b));

  typedef struct packed {
    logic        wr;
    logic [1:0]  len;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 8'h10, 32'h0,        32'h00000001, 4'd1},  // R1 I/O type bit
    '{1'b0, 2'd2, 8'h14, 32'h0,        32'h00000000, 4'd1},  // R1
    '{1'b0, 2'd2, 8'h30, 32'h0,        32'h00000000, 4'd1},  // R1 ROM
    '{1'b1, 2'd2, 8'h10, 32'hFFFFFFFF, 32'h0,        4'd2},
    '{1'b0, 2'd2, 8'h10, 32'h0,        32'hFFFFFFE1, 4'd2},  // R2
    '{1'b1, 2'd2, 8'h14, 32'h12345678, 32'h0,        4'd2},
    '{1'b0, 2'd2, 8'h14, 32'h0,        32'h12345000, 4'd2},  // R2
    '{1'b1, 2'd2, 8'h30, 32'hFFFFFFFF, 32'h0,        4'd3},
    '{1'b0, 2'd2, 8'h30, 32'h0,        32'hFFFFF801, 4'd3},  // R3
    '{1'b1, 2'd2, 8'h30, 32'hABCDE7FE, 32'h0,        4'd3},
    '{1'b0, 2'd2, 8'h30, 32'h0,        32'hABCDE000, 4'd3},  // R3
    '{1'b1, 2'd0, 8'h40, 32'h000000A5, 32'h0,        4'd4},
    '{1'b0, 2'd0, 8'h40, 32'h0,        32'h000000A5, 4'd4},  // R4 writable
    '{1'b1, 2'd2, 8'h00, 32'h11223344, 32'h0,        4'd4},
    '{1'b0, 2'd2, 8'h00, 32'h0,        32'h00000000, 4'd4},  // R4 protected
    '{1'b1, 2'd1, 8'h0C, 32'h0000BEEF, 32'h0,        4'd4},
    '{1'b0, 2'd1, 8'h0C, 32'h0,        32'h0000BEEF, 4'd4},  // R4
    '{1'b1, 2'd0, 8'h0E, 32'h00000055, 32'h0,        4'd4},
    '{1'b0, 2'd0, 8'h0E, 32'h0,        32'h00000000, 4'd4},  // R4
    '{1'b1, 2'd2, 8'h3C, 32'hAABBCCDD, 32'h0,        4'd6},
    '{1'b0, 2'd2, 8'h3C, 32'h0,        32'hAABB00DD, 4'd6},  // R6 per-byte
    '{1'b1, 2'd1, 8'h12, 32'h0000FFFF, 32'h0,        4'd11},
    '{1'b0, 2'd2, 8'h10, 32'h0,        32'hFFFFFFE1, 4'd11}, // R11
    '{1'b1, 2'd2, 8'h1C, 32'hFFFFFFFF, 32'h0,        4'd10},
    '{1'b0, 2'd2, 8'h1C, 32'h0,        32'h00000000, 4'd10}, // R10
    '{1'b1, 2'd2, 8'hFC, 32'h44332211, 32'h0,        4'd7},
    '{1'b0, 2'd2, 8'hFC, 32'h0,        32'h44332211, 4'd7},  // R7
    '{1'b0, 2'd2, 8'hFD, 32'h0,        32'h00003322, 4'd7},  // R7 dword->word
    '{1'b0, 2'd2, 8'hFF, 32'h0,        32'h00000044, 4'd7},  // R7 dword->byte
    '{1'b0, 2'd1, 8'hFE, 32'h0,        32'h00004433, 4'd7},  // R7
    '{1'b1, 2'd2, 8'hFE, 32'hDDCCBBAA, 32'h0,        4'd6},
    '{1'b0, 2'd1, 8'hFE, 32'h0,        32'h0000BBAA, 4'd6},  // R6 stop at 0xFF
    '{1'b1, 2'd2, 8'h41, 32'h04030201, 32'h0,        4'd6},
    '{1'b0, 2'd2, 8'h40, 32'h0,        32'h030201A5, 4'd6},  // R6 unaligned
    '{1'b1, 2'd2, 8'h11, 32'h00000000, 32'h0,        4'd11},
    '{1'b0, 2'd2, 8'h10, 32'h0,        32'hFFFFFFE1, 4'd11}, // R11
    '{1'b0, 2'd3, 8'h40, 32'h0,        32'h030201A5, 4'd7}   // R7 code 3
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] len, input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; acc_len = len; acc_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] len, input logic [7:0] a);
    rd_en = 1'b1; acc_len = len; acc_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "rd_data after reset", rd_a, 32'h0);
    chk("R1", "valid after reset", {25'd0, val_a}, 32'h0);
    chk("R1", "base0 after reset", base_a[31:0], 32'hFFFFFFFF);
    rd(2'd0, 8'h0E);
    chk("R1", "hdr byte a", rd_a, 32'h00);
    chk("R1", "hdr byte b", rd_b, 32'h01);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].len, VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].len, VECS[i].addr);
        chk($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i), rd_a, VECS[i].exp);
      end
    end

    // Decode, command off: nothing valid
    chk("R8", "valid with cmd 0", {25'd0, val_a}, 32'h0);
    wr(2'd1, 8'h04, 32'h0003);
    chk("R9", "valid mem on, io out of range", {25'd0, val_a}, 32'h02);
    chk("R9", "base1", base_a[63:32], 32'h12345000);
    wr(2'd2, 8'h10, 32'h0000C001);
    chk("R8", "io valid", {31'd0, val_a[0]}, 32'd1);
    chk("R8", "io base", base_a[31:0], 32'h0000C000);
    wr(2'd1, 8'h04, 32'h0002);
    chk("R8", "io off by cmd", {31'd0, val_a[0]}, 32'd0);
    chk("R8", "io base when off", base_a[31:0], 32'hFFFFFFFF);
    chk("R9", "mem still on", {31'd0, val_a[1]}, 32'd1);
    wr(2'd1, 8'h04, 32'h0003);
    wr(2'd2, 8'h10, 32'h0000FFE1);
    chk("R8", "io top of 64K", base_a[31:0], 32'h0000FFE0);
    wr(2'd2, 8'h10, 32'h00010001);
    chk("R8", "io above 64K", {31'd0, val_a[0]}, 32'd0);
    wr(2'd2, 8'h10, 32'h00000000);
    chk("R8", "io base zero", {31'd0, val_a[0]}, 32'd0);
    wr(2'd2, 8'h14, 32'hFFFFF000);
    chk("R9", "mem ends at all ones", {31'd0, val_a[1]}, 32'd0);
    wr(2'd2, 8'h14, 32'h80000000);
    wr(2'd1, 8'h04, 32'h0001);
    chk("R9", "mem off by cmd", {31'd0, val_a[1]}, 32'd0);
    wr(2'd1, 8'h04, 32'h0003);
    chk("R9", "mem base", base_a[63:32], 32'h80000000);
    chk("R9", "rom disabled", {31'd0, val_a[6]}, 32'd0);
    wr(2'd2, 8'h30, 32'hABCDE001);
    chk("R9", "rom valid", {31'd0, val_a[6]}, 32'd1);
    chk("R9", "rom base", base_a[223:192], 32'hABCDE000);
    rd(2'd2, 8'h30);
    chk("R3", "rom enable kept", rd_a, 32'hABCDE001);
    wr(2'd2, 8'h18, 32'h0000FFF5);
    chk("R9", "bar2 base", base_a[95:64], 32'h0000FFF0);
    rd(2'd2, 8'h18);
    chk("R2", "bar2 masked", rd_a, 32'h0000FFF0);
    chk("R10", "size-0 regions never valid", {29'd0, val_a[5:3]}, 32'd0);

    // Header type 0x01 instance against header 0x00
    rd(2'd2, 8'h10);
    chk("R2", "bar0 b type bit", rd_b, 32'h00000001);
    wr(2'd2, 8'h1C, 32'hCAFEF00D);
    rd(2'd2, 8'h1C);
    chk("R10", "size-0 bar hdr0", rd_a, 32'h0);
    chk("R5", "size-0 bar hdr1 writable", rd_b, 32'hCAFEF00D);
    wr(2'd2, 8'h38, 32'h11111111);
    rd(2'd2, 8'h38);
    chk("R4", "0x38 writable hdr0", rd_a, 32'h11111111);
    chk("R5", "0x38 protected hdr1", rd_b, 32'h0);
    wr(2'd0, 8'h26, 32'h77);
    rd(2'd0, 8'h26);
    chk("R4", "0x26 protected hdr0", rd_a, 32'h0);
    chk("R5", "0x26 writable hdr1", rd_b, 32'h77);
    rd(2'd0, 8'h0E);
    chk("R5", "hdr byte b protected", rd_b, 32'h01);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule